// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a configuration bitstream into an external programmable device over a passive serial link. A start pulse makes it pull the device's configuration-request line low for a fixed number of cycles and then release it. It then waits, up to a set limit, for the device's status line to report ready. After that it takes bytes from a valid/ready source and shifts each one out on a serial data pin, least significant bit first, with a divided serial clock. The device samples each bit on the rising edge of that clock.

After every byte the block looks at the synchronised status line. A low status level stops the transfer at once. When the byte flagged as last has gone out, the block waits, again up to a limit, for the device's configuration-complete input to rise. The outcome is a success flag or an error flag with a two-bit code. Both stay unchanged until the next accepted start. Reading the bitstream from storage and any start-up clocking after completion belong to the surrounding logic.

Top module: `ps_cfg_master`

## Requirements
- R1: A start pulse while idle drives `tgt_cfg_n_o` low and raises `busy_o` in the first cycle after the start edge. Start is sampled on the rising clock edge.
- R2: `tgt_cfg_n_o` stays low for exactly `RST_LOW_CYC` cycles and then returns high.
- R3: Each byte goes out on `ser_dat_o` with bit 0 first and bit 7 last. The value for each bit is present before the rising edge of `ser_clk_o`, which is the edge where the device samples it.
- R4: Every high phase of `ser_clk_o` lasts exactly `CLK_HALF` cycles. Every low phase lasts at least `CLK_HALF` cycles, and exactly that long between two bits of the same byte. `ser_dat_o` does not change while `ser_clk_o` is high.
- R5: If the synchronised status input stays low for `STAT_POLL_MAX` cycles after `tgt_cfg_n_o` rises, the block ends with error code 1. The error appears exactly `STAT_POLL_MAX` cycles after the rise, and no byte is taken.
- R6: After the eighth bit of a byte, a low synchronised status input ends the sequence with error code 2. No further byte is taken or shifted.
- R7: After the byte marked by `in_last_i`, the block waits for `cfg_done_i`. If it rises in time, the block ends with success. If it does not, error code 3 appears exactly `CDONE_WAIT_MAX + CLK_HALF + 2` cycles after the rising serial clock edge of that byte's bit 7.
- R8: Error codes are 0 for none, 1 for status timeout, 2 for status low during data and 3 for completion timeout. `err_o` is high when the code is not 0, and `done_o` marks success with code 0. All of these hold until the next accepted start, which clears them in the cycle after the start edge.
- R9: A start pulse while busy has no effect. It causes no second low pulse on `tgt_cfg_n_o`, and the transfer in progress completes normally.
- R10: While idle, `tgt_cfg_n_o` is high, `ser_clk_o` is low and `in_ready_o` is low. This also holds straight after reset.
- R11: `in_ready_o` is high only while a new byte can be loaded, never while a byte is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a configuration sequence (ignored while busy) |
| in_valid_i | input | 1 | Source offers a byte |
| in_data_i | input | 8 | Byte offered by the source |
| in_last_i | input | 1 | Offered byte is the final one of the bitstream |
| in_ready_o | output | 1 | Block accepts the offered byte this cycle |
| tgt_cfg_n_o | output | 1 | Active-low configuration request to the device |
| ser_clk_o | output | 1 | Serial clock to the device |
| ser_dat_o | output | 1 | Serial data to the device |
| stat_ok_i | input | 1 | Device status, high while healthy (asynchronous) |
| cfg_done_i | input | 1 | Device configuration-complete indication (asynchronous) |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | Last sequence finished successfully |
| err_o | output | 1 | Last sequence ended with an error |
| err_code_o | output | 2 | Error code of the last sequence |

## Verification
The request line and `busy_o` change one cycle after the start edge. Each serial clock phase lasts `CLK_HALF` cycles. A status timeout appears exactly `STAT_POLL_MAX` cycles after the request line rises, and a completion timeout exactly `CDONE_WAIT_MAX + CLK_HALF + 2` cycles after the last rising serial clock edge. The bench drives inputs and samples outputs on the falling clock edge. A device model stamps each pin transition with a falling-edge cycle number, so each due time is compared as a difference of those stamps. The device model rebuilds the bytes it receives, and the bench compares them with the bytes it sent. Status drop points, ready delays and completion delays are chosen so that each one falls inside or outside its window by a known margin.

// File: rtl/cfgm_pkg.sv
// Package: shared types for the passive serial configuration master.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package cfgm_pkg;

    // Sequencer states of the configuration master.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RSTLOW    = 3'd1,
        ST_STATWAIT  = 3'd2,
        ST_LOAD      = 3'd3,
        ST_SHIFT     = 3'd4,
        ST_BYTECHK   = 3'd5,
        ST_CDONEWAIT = 3'd6
    } cfgm_state_e;

    // Result codes reported when a sequence ends.
    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_STAT_TO  = 2'd1,
        ERR_STAT_LOW = 2'd2,
        ERR_CDONE_TO = 2'd3
    } cfgm_err_e;

endpackage

// File: rtl/cfgm_sync2.sv
// Module: two-flop synchroniser, one chain per bit.
// Assumes: inputs are level signals that stay put for several cycles;
// outputs reset to zero.
module cfgm_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_chain
            logic meta_q;
            logic stab_q;
            // Purpose: move one asynchronous bit into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= async_i[gi];
                    stab_q <= meta_q;
                end
            end
            assign sync_o[gi] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/cfgm_tick.sv
// Module: half-period tick generator for the serial clock.
// Assumes: HALF >= 1. While en_i is high, tick_o pulses once every
// HALF cycles. The count restarts whenever en_i is low.
module cfgm_tick #(
    parameter int HALF = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = en_i && (cnt_q == LAST);

    // Purpose: count cycles within one half period of the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_tick_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/cfgm_serializer.sv
// Module: byte serialiser for the passive serial link.
// Assumes: load_i is only asserted while busy_o is low. Bits leave LSB
// first. Each bit is presented with the clock low for HALF cycles, then
// the clock is high for HALF cycles. fin_o pulses once after the high
// phase of the last bit.
module cfgm_serializer #(
    parameter int HALF = 3,
    parameter int BW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [BW-1:0] data_i,
    output logic          sclk_o,
    output logic          sdat_o,
    output logic          busy_o,
    output logic          fin_o
);

    localparam int IW = (BW > 1) ? $clog2(BW) : 1;
    localparam logic [IW-1:0] LAST_BIT = IW'(BW - 1);

    logic [BW-1:0] shreg_q;
    logic [IW-1:0] bit_idx_q;
    logic          active_q;
    logic          sclk_q;
    logic          sdat_q;
    logic          fin_q;
    logic          tick;

    cfgm_tick #(.HALF(HALF)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (active_q),
        .tick_o (tick)
    );

    // Purpose: walk each bit through its low and high clock phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bit_idx_q <= '0;
            active_q  <= 1'b0;
            sclk_q    <= 1'b0;
            sdat_q    <= 1'b0;
            fin_q     <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load_i && !active_q) begin
                active_q  <= 1'b1;
                sclk_q    <= 1'b0;
                sdat_q    <= data_i[0];
                shreg_q   <= data_i >> 1;
                bit_idx_q <= '0;
            end else if (active_q && tick) begin
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_idx_q == LAST_BIT) begin
                        active_q <= 1'b0;
                        fin_q    <= 1'b1;
                    end else begin
                        bit_idx_q <= bit_idx_q + 1'b1;
                        sdat_q    <= shreg_q[0];
                        shreg_q   <= shreg_q >> 1;
                    end
                end
            end
        end
    end

    assign sclk_o = sclk_q;
    assign sdat_o = sdat_q;
    assign busy_o = active_q;
    assign fin_o  = fin_q;

    // R4: data may not move while the device can be sampling it.
    assert_dat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && $past(sclk_q)) |-> $stable(sdat_q));

    // R3: the finish pulse is a single cycle wide and ends the byte.
    assert_fin_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |-> (!active_q && !sclk_q));

endmodule

// File: rtl/ps_cfg_master.sv
// Module: passive serial configuration master (top).
// Assumes: stat_ok_i and cfg_done_i are asynchronous levels driven by the
// device. Bytes arrive on a valid/ready source, with in_last_i marking the
// final byte. Timeouts are counted in system clock cycles.
module ps_cfg_master
    import cfgm_pkg::*;
#(
    parameter int CLK_HALF       = 3,
    parameter int RST_LOW_CYC    = 8,
    parameter int STAT_POLL_MAX  = 30000,
    parameter int CDONE_WAIT_MAX = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       in_valid_i,
    input  logic [7:0] in_data_i,
    input  logic       in_last_i,
    output logic       in_ready_o,
    output logic       tgt_cfg_n_o,
    output logic       ser_clk_o,
    output logic       ser_dat_o,
    input  logic       stat_ok_i,
    input  logic       cfg_done_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic [1:0] err_code_o
);

    localparam int T_A  = (STAT_POLL_MAX > CDONE_WAIT_MAX) ? STAT_POLL_MAX : CDONE_WAIT_MAX;
    localparam int TMAX = (T_A > RST_LOW_CYC) ? T_A : RST_LOW_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] RST_LAST   = TW'(RST_LOW_CYC - 1);
    localparam logic [TW-1:0] STAT_LAST  = TW'(STAT_POLL_MAX - 1);
    localparam logic [TW-1:0] CDONE_LAST = TW'(CDONE_WAIT_MAX - 1);

    cfgm_state_e   state_q;
    cfgm_err_e     code_q;
    logic [TW-1:0] timer_q;
    logic          last_q;
    logic          cfg_n_q;
    logic          done_q;
    logic          stat_s;
    logic          cdone_s;
    logic          ser_load;
    logic          ser_busy;
    logic          ser_fin;

    cfgm_sync2 #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({stat_ok_i, cfg_done_i}),
        .sync_o  ({stat_s, cdone_s})
    );

    assign in_ready_o = (state_q == ST_LOAD);
    assign ser_load   = in_ready_o && in_valid_i;

    cfgm_serializer #(.HALF(CLK_HALF), .BW(8)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ser_load),
        .data_i (in_data_i),
        .sclk_o (ser_clk_o),
        .sdat_o (ser_dat_o),
        .busy_o (ser_busy),
        .fin_o  (ser_fin)
    );

    // Purpose: sequence reset pulse, handshakes, byte loop and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= ERR_NONE;
            timer_q <= '0;
            last_q  <= 1'b0;
            cfg_n_q <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RSTLOW;
                        timer_q <= '0;
                        cfg_n_q <= 1'b0;
                        done_q  <= 1'b0;
                        code_q  <= ERR_NONE;
                    end
                end
                ST_RSTLOW: begin
                    if (timer_q == RST_LAST) begin
                        state_q <= ST_STATWAIT;
                        timer_q <= '0;
                        cfg_n_q <= 1'b1;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                ST_STATWAIT: begin
                    if (stat_s) begin
                        state_q <= ST_LOAD;
                    end else if (timer_q == STAT_LAST) begin
                        state_q <= ST_IDLE;
                        code_q  <= ERR_STAT_TO;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                ST_LOAD: begin
                    if (in_valid_i) begin
                        last_q  <= in_last_i;
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (ser_fin) begin
                        state_q <= ST_BYTECHK;
                    end
                end
                ST_BYTECHK: begin
                    if (!stat_s) begin
                        state_q <= ST_IDLE;
                        code_q  <= ERR_STAT_LOW;
                    end else if (last_q) begin
                        state_q <= ST_CDONEWAIT;
                        timer_q <= '0;
                    end else begin
                        state_q <= ST_LOAD;
                    end
                end
                ST_CDONEWAIT: begin
                    if (cdone_s) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else if (timer_q == CDONE_LAST) begin
                        state_q <= ST_IDLE;
                        code_q  <= ERR_CDONE_TO;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign tgt_cfg_n_o = cfg_n_q;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign err_o       = (code_q != ERR_NONE);
    assign err_code_o  = code_q;

    // R10: idle pin levels.
    assert_idle_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (tgt_cfg_n_o && !ser_clk_o && !in_ready_o));

    // R11: a byte is only offered a slot while the serialiser is free.
    assert_ready_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> !ser_busy);

    // R5: the status poll counter never passes its limit.
    assert_poll_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STATWAIT) |-> (timer_q < TW'(STAT_POLL_MAX)));

    // R6: a low status seen at the byte check ends with code 2.
    assert_stat_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BYTECHK && !stat_s) |=> (err_code_o == 2'd2 && !busy_o));

    // R8: results hold until a start arrives.
    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);
    assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> $stable(err_code_o));

    // R9: start during a running transfer never re-asserts the request.
    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_q != ST_RSTLOW && start_i) |=> tgt_cfg_n_o);

endmodule

// File: tb/ps_cfg_master_tb_top.sv
// Bench: random and directed configuration runs against a device model.
module ps_cfg_master_tb_top;

    localparam int HALF  = 3;
    localparam int RSTL  = 8;
    localparam int SPMAX = 40;
    localparam int CDMAX = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       in_valid_i = 1'b0;
    logic [7:0] in_data_i = 8'h00;
    logic       in_last_i = 1'b0;
    logic       in_ready_o;
    logic       tgt_cfg_n_o;
    logic       ser_clk_o;
    logic       ser_dat_o;
    logic       stat_ok_i = 1'b0;
    logic       cfg_done_i = 1'b0;
    logic       busy_o;
    logic       done_o;
    logic       err_o;
    logic [1:0] err_code_o;

    ps_cfg_master #(
        .CLK_HALF(HALF), .RST_LOW_CYC(RSTL),
        .STAT_POLL_MAX(SPMAX), .CDONE_WAIT_MAX(CDMAX)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_last_i(in_last_i),
        .in_ready_o(in_ready_o), .tgt_cfg_n_o(tgt_cfg_n_o),
        .ser_clk_o(ser_clk_o), .ser_dat_o(ser_dat_o),
        .stat_ok_i(stat_ok_i), .cfg_done_i(cfg_done_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // device-model configuration, written by tasks only
    int mdl_stat_dly = 0;
    int mdl_drop_bit = 0;
    int mdl_cd_dly   = 0;
    int mdl_len      = 0;

    // device-model state, written by the model only
    int   cyc = 0;
    logic prev_cfg = 1'b1;
    logic prev_sclk = 1'b0;
    logic prev_err = 1'b0;
    int   cfg_falls = 0;
    int   rst_run = 0;
    int   rst_len = 0;
    int   since_rel = 0;
    int   rel_cyc = 0;
    int   err_cyc = 0;
    int   last_bit_cyc = 0;
    int   rx_bits = 0;
    bit   dropped = 1'b0;
    int   cd_cnt = 0;
    int   run = 0;
    int   hi_bad = 0;
    int   lo_bad = 0;
    int   rdy_bad = 0;
    logic [7:0] rx_q [0:15];
    logic [7:0] tx_q [0:15];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Device model: reacts to the pins, sampled on the falling edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (!tgt_cfg_n_o) begin
                if (prev_cfg) begin
                    cfg_falls = cfg_falls + 1;
                    rx_bits = 0; dropped = 1'b0; rst_run = 0; cd_cnt = 0;
                end
                rst_run = rst_run + 1;
                stat_ok_i = 1'b0; cfg_done_i = 1'b0; since_rel = 0;
            end else begin
                if (!prev_cfg) begin rst_len = rst_run; rel_cyc = cyc; end
                since_rel = since_rel + 1;
                if (mdl_stat_dly >= 0 && since_rel > mdl_stat_dly && !dropped) stat_ok_i = 1'b1;
            end
            if (ser_clk_o && !prev_sclk) begin
                if (rx_bits < 128) rx_q[rx_bits / 8][rx_bits % 8] = ser_dat_o;
                rx_bits = rx_bits + 1;
                last_bit_cyc = cyc;
                if (mdl_drop_bit > 0 && rx_bits == mdl_drop_bit) begin
                    dropped = 1'b1; stat_ok_i = 1'b0;
                end
            end
            if (ser_clk_o == prev_sclk) run = run + 1;
            else begin
                if (prev_sclk && run != HALF) hi_bad = hi_bad + 1;
                if (!prev_sclk && run < HALF) lo_bad = lo_bad + 1;
                run = 1;
            end
            if (in_ready_o && ser_clk_o) rdy_bad = rdy_bad + 1;
            if (mdl_cd_dly >= 0 && mdl_len > 0 && rx_bits == mdl_len * 8 && tgt_cfg_n_o) begin
                cd_cnt = cd_cnt + 1;
                if (cd_cnt > mdl_cd_dly) cfg_done_i = 1'b1;
            end
            if (err_o && !prev_err) err_cyc = cyc;
        end
        prev_cfg = tgt_cfg_n_o; prev_sclk = ser_clk_o; prev_err = err_o;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            summary();
        end
    end

    // Source: offers bytes until all are taken or the sequence ends.
    task automatic feed(input int len);
        for (int i = 0; i < len; i++) begin
            bit taken;
            bit quit;
            taken = 1'b0;
            quit = 1'b0;
            repeat ($urandom % 3) @(negedge clk);
            in_valid_i = 1'b1; in_data_i = tx_q[i]; in_last_i = (i == len - 1);
            while (!taken && !quit) begin
                if (in_ready_o) taken = 1'b1;
                else if (!busy_o) quit = 1'b1;
                @(negedge clk);
            end
            in_valid_i = 1'b0; in_last_i = 1'b0;
            if (quit) break;
        end
    endtask

    task automatic run_case(input int len, input int sdly, input int drop_bit,
                            input int cdly, input bit ext_start, input int exp_code);
        int f0;
        int exp_bits;
        mdl_len = len; mdl_stat_dly = sdly; mdl_drop_bit = drop_bit; mdl_cd_dly = cdly;
        hi_bad = 0; lo_bad = 0; rdy_bad = 0;
        f0 = cfg_falls;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(tgt_cfg_n_o == 1'b0 && busy_o, "R1 start response", int'(tgt_cfg_n_o), 0);
        chk(!done_o && !err_o, "R8 cleared by start", int'(err_code_o), 0);
        fork
            feed(len);
            begin
                while (!(done_o || err_o)) @(negedge clk);
            end
            begin
                if (ext_start) begin
                    repeat (30) @(negedge clk);
                    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
                end
            end
        join
        repeat (30) @(negedge clk);
        chk(err_code_o == 2'(exp_code), "R8 code", int'(err_code_o), exp_code);
        chk(done_o == (exp_code == 0) && err_o == (exp_code != 0), "R8 flags held",
            int'(done_o), int'(exp_code == 0));
        chk(rst_len == RSTL, "R2 request pulse width", rst_len, RSTL);
        chk(cfg_falls - f0 == 1, ext_start ? "R9 start ignored" : "R2 single pulse",
            cfg_falls - f0, 1);
        chk(tgt_cfg_n_o && !ser_clk_o && !in_ready_o, "R10 idle pins",
            int'(ser_clk_o), 0);
        chk(hi_bad == 0 && lo_bad == 0, "R4 clock phases", hi_bad + lo_bad, 0);
        chk(rdy_bad == 0, "R11 ready while shifting", rdy_bad, 0);
        exp_bits = (exp_code == 1) ? 0 :
                   (exp_code == 2) ? ((drop_bit - 1) / 8 + 1) * 8 : len * 8;
        chk(rx_bits == exp_bits, exp_code == 2 ? "R6 bits before stop" : "R3 bit count",
            rx_bits, exp_bits);
        if (exp_code == 0 || exp_code == 3) begin
            for (int i = 0; i < len; i++)
                chk(rx_q[i] == tx_q[i], "R3 byte order LSB first", int'(rx_q[i]), int'(tx_q[i]));
        end
        if (exp_code == 1)
            chk(err_cyc - rel_cyc == SPMAX, "R5 timeout cycle", err_cyc - rel_cyc, SPMAX);
        if (exp_code == 3)
            chk(err_cyc - last_bit_cyc == CDMAX + HALF + 2, "R7 timeout cycle",
                err_cyc - last_bit_cyc, CDMAX + HALF + 2);
        if (exp_code == 0 && cdly >= 0)
            chk(done_o, "R7 completion in time", int'(done_o), 1);
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (4) @(negedge clk);
        chk(tgt_cfg_n_o && !ser_clk_o && !in_ready_o, "R10 reset pins", int'(tgt_cfg_n_o), 1);
        chk(!busy_o && !done_o && !err_o && err_code_o == 2'd0, "R8 reset flags",
            int'(err_code_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // directed: asymmetric single byte
        tx_q[0] = 8'h1D;
        run_case(1, 2, 0, 5, 1'b0, 0);
        // random successful runs
        for (int k = 0; k < 6; k++) begin
            int len;
            len = 1 + int'($urandom % 6);
            for (int i = 0; i < len; i++) tx_q[i] = 8'($urandom);
            run_case(len, int'($urandom % 20), 0, int'($urandom % 30), 1'b0, 0);
        end
        // R5: status never rises
        run_case(3, -1, 0, 0, 1'b0, 1);
        // R6: status drops inside a random byte
        begin
            int d;
            d = int'($urandom % 4);
            for (int i = 0; i < 5; i++) tx_q[i] = 8'($urandom);
            run_case(5, 3, d * 8 + 5, 0, 1'b0, 2);
        end
        // R6: status drops in the final byte
        run_case(2, 1, 13, 0, 1'b0, 2);
        // R7: completion never arrives
        for (int i = 0; i < 2; i++) tx_q[i] = 8'($urandom);
        run_case(2, 4, 0, -1, 1'b0, 3);
        // R7: completion late but inside the window
        tx_q[0] = 8'h80;
        run_case(1, 0, 0, CDMAX - 10, 1'b0, 0);
        // R9: extra start while busy
        for (int i = 0; i < 3; i++) tx_q[i] = 8'($urandom);
        run_case(3, 5, 0, 7, 1'b1, 0);

        summary();
    end

endmodule